// File: doc/BRIEF.md
# CAS Timeslot-16 Signalling Multiplexer

This block builds and takes apart timeslot 16 of a 32-timeslot E1-style frame. It works across a 16-frame channel-associated-signalling multiframe. The multiframe position comes from outside as a frame number. A one-cycle strobe marks the timeslot-16 byte position. The block does not search for multiframe alignment and does not check CRC-4.

On transmit, a host fills a table with one 4-bit ABCD code for each of the 30 payload channels. Each basic frame k (1..15) sends two codes at once. Channel k goes in the high nibble and channel k+15 goes in the low nibble. Frame 0 sends instead the multiframe alignment word and three programmable spare bits.

On receive, the same byte layout is decoded into a receive table. The decode only happens while an external qualifier says the frame is valid and multiframe-aligned. Every accepted frame raises a one-cycle update strobe. The strobe carries the frame number that was written.

Top module: `cas_sig_mux`

## Requirements
- R1: For frame 0, the transmit byte is, from MSB to LSB: 0,0,0,0, spare[2], 1, spare[1], spare[0].
- R2: The 3-bit spare register resets to 3'b111, so the frame-0 byte is 8'h0F after reset. A write with `spare_wr_en` replaces the register from the next cycle on.
- R3: For frame k (1..15), the transmit byte is {code of channel k, code of channel k+15}. The high nibble is bits 7:4.
- R4: `tx_ts16_valid` is high exactly one cycle after a cycle with `ts16_strobe` high, and is low otherwise. `tx_ts16_byte` holds the byte for the strobed frame in that cycle.
- R5: A host write with `tx_wr_chan` from 1 to 30 stores `tx_wr_code` for that channel. Channel numbers 0 and 31 are ignored.
- R6: If a host write to a channel lands in the same cycle as the strobe for that channel's frame, that byte still carries the old code. The new code appears at the next occurrence of the frame.
- R7: Reset loads the idle code 4'hD into every entry of both tables. Reset also clears `tx_ts16_valid`, `tx_ts16_byte`, `rx_upd` and `rx_upd_frame`.
- R8: When `ts16_strobe` and `rx_mf_aligned` are both high and the frame k is in 1..15, channel k takes `rx_ts16_byte[7:4]` and channel k+15 takes `rx_ts16_byte[3:0]`. The new values can be read through `rx_rd_chan`/`rx_rd_code` in the next cycle.
- R9: No receive update happens, and `rx_upd` stays low, in three cases: the strobe is low, the qualifier is low, or the frame number is 0.
- R10: Each accepted receive frame gives a single-cycle `rx_upd` pulse in the next cycle, with `rx_upd_frame` equal to the frame written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_num | input | 4 | Basic frame position within the multiframe (0..15) |
| ts16_strobe | input | 1 | Marks the timeslot-16 byte cycle |
| tx_wr_en | input | 1 | Host write to the transmit table |
| tx_wr_chan | input | 5 | Channel to write (1..30) |
| tx_wr_code | input | 4 | ABCD code to store |
| spare_wr_en | input | 1 | Load the spare-bit register |
| spare_wr_val | input | 3 | New spare bits {bit5, bit7, bit8} |
| tx_ts16_byte | output | 8 | Transmit timeslot-16 byte |
| tx_ts16_valid | output | 1 | Transmit byte is new this cycle |
| rx_ts16_byte | input | 8 | Received timeslot-16 byte |
| rx_mf_aligned | input | 1 | Frame valid and multiframe-aligned qualifier |
| rx_rd_chan | input | 5 | Receive table read channel (1..30) |
| rx_rd_code | output | 4 | Stored code of the selected channel (0 when the channel is out of range) |
| rx_upd | output | 1 | One-cycle pulse after a receive table update |
| rx_upd_frame | output | 4 | Frame number of the last update |

## Verification
The assertions check, on every cycle:
- the alignment pattern in every frame-0 transmit byte;
- that the valid flag follows the strobe by exactly one cycle;
- that the spare register and both tables hold their values unless a qualified write or update occurs;
- that each accepted receive frame lands in the correct high-nibble channel and raises the strobe with the right frame number.

Only the bench scenarios can show:
- the full channel-to-nibble pairing over all fifteen frames;
- the read-before-write ordering when a host write meets its own frame;
- the exact byte values for different spare settings;
- that rejected receive frames leave the readable codes unchanged.

// File: rtl/cas_sig_pkg.sv
// Package: shared sizes and types of the timeslot-16 signalling block.
// Assumes a 16-frame multiframe and 30 payload channels split into two halves.
package cas_sig_pkg;
    localparam int CODE_W  = 4;             // ABCD code width
    localparam int NCH     = 30;            // payload channels
    localparam int HALF    = NCH / 2;       // channels per nibble half
    localparam int FRM_W   = 4;             // frame number width
    localparam int CH_W    = 5;             // channel number width
    localparam int BYTE_W  = 2 * CODE_W;    // timeslot byte width
    localparam int SPARE_W = 3;             // spare bits in frame 0

    typedef logic [CODE_W-1:0] abcd_t;
    typedef logic [NCH-1:0][CODE_W-1:0] sig_table_t;
endpackage

// File: rtl/cas_tx_table.sv
// Transmit signalling table: one ABCD code per channel.
// A host write port stores codes. A read port selects the two channels carried by a frame.
// Reads are combinational from the stored flops, so a write in the same cycle as a read
// is only seen from the following cycle on.
module cas_tx_table
    import cas_sig_pkg::*;
#(
    parameter abcd_t IDLE_CODE = 4'hD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  abcd_t            wr_code,
    input  logic [FRM_W-1:0] rd_frame,
    output abcd_t            rd_hi,
    output abcd_t            rd_lo
);
    sig_table_t tbl;
    logic [CH_W-1:0] hi_idx;
    logic [CH_W-1:0] lo_idx;
    logic            wr_ok;

    assign wr_ok  = wr_en && (wr_chan != '0) && (wr_chan <= CH_W'(NCH));
    assign hi_idx = CH_W'(rd_frame) - CH_W'(1);
    assign lo_idx = hi_idx + CH_W'(HALF);

    // Store host codes; reset loads the idle code into every channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) tbl[i] <= IDLE_CODE;
        end else if (wr_ok) begin
            tbl[wr_chan - CH_W'(1)] <= wr_code;
        end
    end

    // Select channel k and channel k+15 for frame k; frame 0 carries no codes.
    always_comb begin
        rd_hi = '0;
        rd_lo = '0;
        if (rd_frame != '0) begin
            rd_hi = tbl[hi_idx];
            rd_lo = tbl[lo_idx];
        end
    end

    // R5: an invalid or absent write leaves the whole table untouched
    a_r5_ignore_bad_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_chan == '0 || wr_chan > CH_W'(NCH)) |=> $stable(tbl));
endmodule

// File: rtl/cas_tx_builder.sv
// Transmit byte builder for timeslot 16.
// Frame 0 gets the alignment word, a fixed one in bit 6, and the programmable spare bits.
// Frames 1..15 get the two table codes. The byte is registered on the strobe.
// Assumes the table read data is valid in the strobe cycle.
module cas_tx_builder
    import cas_sig_pkg::*;
#(
    parameter logic [SPARE_W-1:0] SPARE_RST = 3'b111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strb,
    input  logic [FRM_W-1:0]   frame,
    input  logic               spare_we,
    input  logic [SPARE_W-1:0] spare_val,
    input  abcd_t              hi_code,
    input  abcd_t              lo_code,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               tx_valid
);
    localparam abcd_t MFAS = '0;

    logic [SPARE_W-1:0] spare_q;
    logic [BYTE_W-1:0]  nxt;

    // Hold the spare bits; load on host request.
    always_ff @(posedge clk) begin
        if (!rst_n)        spare_q <= SPARE_RST;
        else if (spare_we) spare_q <= spare_val;
    end

    // Form the byte for the current frame.
    always_comb begin
        if (frame == '0) nxt = {MFAS, spare_q[2], 1'b1, spare_q[1], spare_q[0]};
        else             nxt = {hi_code, lo_code};
    end

    // Register the byte on the timeslot strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte  <= '0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= strb;
            if (strb) tx_byte <= nxt;
        end
    end

    // R1: frame 0 always yields the alignment nibble and the fixed one
    a_r1_frame0_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && frame == '0) |=> (tx_byte[7:4] == MFAS && tx_byte[2]));
    // R4: the valid flag follows the strobe by one cycle
    a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strb |=> tx_valid);
    a_r4_no_valid_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strb |=> !tx_valid);
    // R2: spare bits change only on a load
    a_r2_spare_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !spare_we |=> $stable(spare_q));
endmodule

// File: rtl/cas_rx_parser.sv
// Receive signalling decoder.
// On a qualified timeslot-16 byte of frame k (1..15), it stores the high nibble as channel k
// and the low nibble as channel k+15, then pulses an update strobe.
// Assumes the multiframe qualifier is produced outside.
module cas_rx_parser
    import cas_sig_pkg::*;
#(
    parameter abcd_t IDLE_CODE = 4'hD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb,
    input  logic              align_ok,
    input  logic [FRM_W-1:0]  frame,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [CH_W-1:0]   rd_chan,
    output abcd_t             rd_code,
    output logic              upd,
    output logic [FRM_W-1:0]  upd_frame
);
    sig_table_t      tbl;
    logic            upd_en;
    logic [CH_W-1:0] hi_idx;
    logic [CH_W-1:0] lo_idx;
    logic [CH_W-1:0] rd_idx;

    assign upd_en = strb && align_ok && (frame != '0);
    assign hi_idx = CH_W'(frame) - CH_W'(1);
    assign lo_idx = hi_idx + CH_W'(HALF);
    assign rd_idx = rd_chan - CH_W'(1);

    // Write both channel nibbles of an accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) tbl[i] <= IDLE_CODE;
        end else if (upd_en) begin
            tbl[hi_idx] <= rx_byte[BYTE_W-1:CODE_W];
            tbl[lo_idx] <= rx_byte[CODE_W-1:0];
        end
    end

    // Pulse the update strobe and remember the frame written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd       <= 1'b0;
            upd_frame <= '0;
        end else begin
            upd <= upd_en;
            if (upd_en) upd_frame <= frame;
        end
    end

    // Read one channel; out-of-range numbers return zero.
    always_comb begin
        rd_code = '0;
        if (rd_chan != '0 && rd_chan <= CH_W'(NCH)) rd_code = tbl[rd_idx];
    end

    // R9: no qualified frame means no strobe and an unchanged table
    a_r9_quiet_when_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> (!upd && $stable(tbl)));
    // R10: an accepted frame pulses the strobe with its frame number
    a_r10_pulse_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (upd && upd_frame == $past(frame)));
    // R8: the high nibble lands in channel k
    a_r8_high_nibble_stored: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (tbl[$past(hi_idx)] == $past(rx_byte[BYTE_W-1:CODE_W])));
endmodule

// File: rtl/cas_sig_mux.sv
// Top: timeslot-16 channel-associated signalling multiplexer.
// It combines the transmit table, the transmit byte builder and the receive decoder.
// The frame number and the timeslot strobe are shared by both directions and come from outside.
module cas_sig_mux
    import cas_sig_pkg::*;
#(
    parameter abcd_t              IDLE_CODE = 4'hD,
    parameter logic [SPARE_W-1:0] SPARE_RST = 3'b111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRM_W-1:0]   frame_num,
    input  logic               ts16_strobe,
    input  logic               tx_wr_en,
    input  logic [CH_W-1:0]    tx_wr_chan,
    input  logic [CODE_W-1:0]  tx_wr_code,
    input  logic               spare_wr_en,
    input  logic [SPARE_W-1:0] spare_wr_val,
    output logic [BYTE_W-1:0]  tx_ts16_byte,
    output logic               tx_ts16_valid,
    input  logic [BYTE_W-1:0]  rx_ts16_byte,
    input  logic               rx_mf_aligned,
    input  logic [CH_W-1:0]    rx_rd_chan,
    output logic [CODE_W-1:0]  rx_rd_code,
    output logic               rx_upd,
    output logic [FRM_W-1:0]   rx_upd_frame
);
    abcd_t hi_code;
    abcd_t lo_code;

    cas_tx_table #(.IDLE_CODE(IDLE_CODE)) u_tx_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tx_wr_en),
        .wr_chan  (tx_wr_chan),
        .wr_code  (tx_wr_code),
        .rd_frame (frame_num),
        .rd_hi    (hi_code),
        .rd_lo    (lo_code)
    );

    cas_tx_builder #(.SPARE_RST(SPARE_RST)) u_tx_builder (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (ts16_strobe),
        .frame     (frame_num),
        .spare_we  (spare_wr_en),
        .spare_val (spare_wr_val),
        .hi_code   (hi_code),
        .lo_code   (lo_code),
        .tx_byte   (tx_ts16_byte),
        .tx_valid  (tx_ts16_valid)
    );

    cas_rx_parser #(.IDLE_CODE(IDLE_CODE)) u_rx_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb      (ts16_strobe),
        .align_ok  (rx_mf_aligned),
        .frame     (frame_num),
        .rx_byte   (rx_ts16_byte),
        .rd_chan   (rx_rd_chan),
        .rd_code   (rx_rd_code),
        .upd       (rx_upd),
        .upd_frame (rx_upd_frame)
    );
endmodule

// File: tb/cas_sig_mux_test.sv
module cas_sig_mux_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] frame_num = '0;
    logic       ts16_strobe = 1'b0;
    logic       tx_wr_en = 1'b0;
    logic [4:0] tx_wr_chan = '0;
    logic [3:0] tx_wr_code = '0;
    logic       spare_wr_en = 1'b0;
    logic [2:0] spare_wr_val = '0;
    logic [7:0] tx_ts16_byte;
    logic       tx_ts16_valid;
    logic [7:0] rx_ts16_byte = '0;
    logic       rx_mf_aligned = 1'b0;
    logic [4:0] rx_rd_chan = 5'd1;
    logic [3:0] rx_rd_code;
    logic       rx_upd;
    logic [3:0] rx_upd_frame;

    int  total = 0;
    int  fails = 0;
    bit  done = 1'b0;
    logic [3:0] txm [0:31];
    logic [3:0] rxm [0:31];

    // receive vectors: {frame, byte}
    localparam logic [11:0] RXV [0:7] = '{12'h1A5, 12'h23C, 12'hF96, 12'h70F,
                                          12'h8F0, 12'h512, 12'hE7E, 12'h15A};

    cas_sig_mux uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Strobe one transmit frame; check the registered byte one cycle later.
    task automatic tx_frame(input logic [3:0] f, input logic [7:0] exp, input string req);
        frame_num = f; ts16_strobe = 1'b1;
        @(negedge clk);
        ts16_strobe = 1'b0;
        chk(req, tx_ts16_valid, 1'b1);
        chk(req, tx_ts16_byte, exp);
    endtask

    task automatic tx_write(input logic [4:0] c, input logic [3:0] code);
        tx_wr_en = 1'b1; tx_wr_chan = c; tx_wr_code = code;
        @(negedge clk);
        tx_wr_en = 1'b0;
        if (c >= 1 && c <= 30) txm[c] = code;
    endtask

    // Apply one receive byte; check the strobe and both channel codes.
    task automatic rx_frame(input logic [3:0] f, input logic [7:0] b, input logic al,
                            input logic stb, input string req);
        logic take;
        take = stb && al && (f != 0);
        frame_num = f; rx_ts16_byte = b; rx_mf_aligned = al; ts16_strobe = stb;
        @(negedge clk);
        ts16_strobe = 1'b0; rx_mf_aligned = 1'b0;
        if (take) begin
            rxm[f] = b[7:4];
            rxm[f + 15] = b[3:0];
        end
        chk(req, rx_upd, take);
        if (take) chk(req, rx_upd_frame, f);
        if (f != 0) begin
            rx_rd_chan = 5'(f); #1;
            chk(req, rx_rd_code, rxm[f]);
            rx_rd_chan = 5'(f) + 5'd15; #1;
            chk(req, rx_rd_code, rxm[f + 15]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin txm[i] = 4'hD; rxm[i] = 4'hD; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state
        chk("R7 valid", tx_ts16_valid, 1'b0);
        chk("R7 byte", tx_ts16_byte, 8'h00);
        chk("R7 upd", rx_upd, 1'b0);
        chk("R7 upd_frame", rx_upd_frame, 4'h0);
        rx_rd_chan = 5'd30; #1;
        chk("R7 rx idle", rx_rd_code, 4'hD);
        tx_frame(4'd3, 8'hDD, "R7 tx idle");
        // R1 R2: frame 0 with reset spare bits
        tx_frame(4'd0, 8'h0F, "R2 spare reset");
        // R4: valid drops without strobe
        @(negedge clk);
        chk("R4 valid low", tx_ts16_valid, 1'b0);

        // R8 R10: table-driven receive vectors
        for (int i = 0; i < 8; i++)
            rx_frame(RXV[i][11:8], RXV[i][7:0], 1'b1, 1'b1, "R8 vector");
        @(negedge clk);
        chk("R10 single pulse", rx_upd, 1'b0);

        // R9: rejected receive frames
        rx_frame(4'd1, 8'h33, 1'b0, 1'b1, "R9 unaligned");
        rx_frame(4'd0, 8'h44, 1'b1, 1'b1, "R9 frame0");
        rx_frame(4'd2, 8'h55, 1'b1, 1'b0, "R9 no strobe");

        // R3 R5: fill transmit table, sweep every frame
        for (int c = 1; c <= 30; c++) tx_write(5'(c), 4'((c * 5 + 2) & 15));
        for (int k = 1; k <= 15; k++) tx_frame(4'(k), {txm[k], txm[k + 15]}, "R3 pairing");
        tx_write(5'd0, 4'h1);
        tx_write(5'd31, 4'h1);
        tx_frame(4'd1, {txm[1], txm[16]}, "R5 chan0 ignored");
        tx_frame(4'd15, {txm[15], txm[30]}, "R5 chan31 ignored");

        // R1 R2: programmed spare bits
        spare_wr_en = 1'b1; spare_wr_val = 3'b010;
        @(negedge clk);
        spare_wr_en = 1'b0;
        tx_frame(4'd0, 8'h06, "R1 spare 010");
        spare_wr_en = 1'b1; spare_wr_val = 3'b000;
        @(negedge clk);
        spare_wr_en = 1'b0;
        tx_frame(4'd0, 8'h04, "R1 spare 000");

        // R6: write meets its own frame strobe
        begin
            logic [3:0] old4;
            logic [3:0] old19;
            old4 = txm[4];
            old19 = txm[19];
            tx_wr_en = 1'b1; tx_wr_chan = 5'd4; tx_wr_code = ~old4;
            tx_frame(4'd4, {old4, old19}, "R6 old code");
            tx_wr_en = 1'b0;
            txm[4] = ~old4;
            tx_frame(4'd4, {txm[4], old19}, "R6 new code");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule